// File: doc/BRIEF.md
# NOR Flash Program/Erase Status Poller

This controller sits on the host side of a NOR flash bus and runs a complete embedded program or sector-erase operation for a requester. After a start pulse, it writes the unlock cycles and the command cycles. It then reads the status word at the target address until the device reports that it has finished. The decision rests on the toggle bit (bit 6): while the device is working, that bit changes on every read. When two back-to-back reads agree, the word or sector is finished.

If a read shows bit 6 still changing and the timeout flag (bit 5) set, the controller takes two fresh reads. The toggling may have stopped at the same moment the flag appeared. If those two reads still differ, the operation has failed. The controller then writes the reset command and signals an error. A program request can cover several consecutive words. The requester sees a pulse each time a word is accepted and supplies the next data word. Erase reads also toggle bit 2 on the sector under erase; the controller does not use that bit.

Top module: `flash_op_poller`

## Requirements
- R1: While reset is held and after it is released, before any start, `busy`, `done`, `error`, `word_taken` and `fl_req` are all 0.
- R2: A program operation writes (555h, 00AAh), (2AAh, 0055h), (555h, 00A0h), then (word address, data word), in that order.
- R3: A sector erase writes (555h, 00AAh), (2AAh, 0055h), (555h, 0080h), (555h, 00AAh), (2AAh, 0055h), then (sector address, 0030h), in that order.
- R4: After the command writes, every read targets the word or sector address. Reads continue until bit 6 of two consecutive reads is equal, and that equality ends the word with success.
- R5: Bit 2 of the status word has no effect on the outcome or on the number of reads.
- R6: If a read still differs in bit 6 from the previous read and has bit 5 set, exactly two further reads follow. If bit 6 of those two is equal, the operation succeeds.
- R7: If bit 6 of those two recheck reads still differs, the controller writes data 00F0h and then pulses `error`. It does not pulse `done` or program further words.
- R8: `word_cnt` gives the number of words for a program operation, and 0 counts as 1. Each word goes to the next higher address. `word_taken` pulses once per successful word, and data for word k is sampled after k pulses. Erase ignores `word_cnt` and never pulses `word_taken`.
- R9: `done` and `error` are single-cycle pulses, never together, and `busy` is low when either is high. `busy` is high throughout an operation, and a `start` received while busy is ignored.
- R10: Once `fl_req` is raised, it and `fl_we`, `fl_addr` and `fl_wdata` stay unchanged until a cycle with `fl_ack` high. Each such cycle completes exactly one bus access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, sampled while idle |
| op_erase | input | 1 | 1 selects sector erase, 0 selects program |
| base_addr | input | AW | First word address, or the sector address |
| word_cnt | input | CW | Number of words to program (0 means 1) |
| pgm_data | input | DW | Data for the current word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Success pulse |
| error | output | 1 | Failure pulse, after the reset write |
| word_taken | output | 1 | Pulse per successfully programmed word |
| fl_req | output | 1 | Bus access request |
| fl_we | output | 1 | 1 for a write, 0 for a read |
| fl_addr | output | AW | Bus address |
| fl_wdata | output | DW | Write data |
| fl_rdata | input | DW | Read data, valid with fl_ack |
| fl_ack | input | 1 | Access complete |

## Verification
The delicate case is the timeout flag and the end of toggling arriving in one status read. A flash model in the bench provokes it by setting bit 5 on exactly the read where bit 6 stops changing. The expectation is immediate success with no recheck reads. A neighbouring case has bit 5 appear on the last toggling read. That one must cost exactly two more reads and still end in `done`, while a device that keeps toggling must produce the 00F0h write and `error`. The bench judges each case by counting reads and writes at the bus and by comparing every write against the expected sequence.

// File: rtl/flpoll_pkg.sv
// Shared types and command bytes for the flash status poller.
// Assumes the flash data bus is at least 8 bits wide; commands occupy bits 7:0.
package flpoll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,      // waiting for start
        ST_CMD,       // issuing unlock/command writes
        ST_RD_FIRST,  // first status read after the commands
        ST_RD_NEXT,   // sliding comparison of consecutive reads
        ST_RCK_A,     // first recheck read after timeout flag
        ST_RCK_B,     // second recheck read
        ST_RST_WR     // reset write after failure
    } poll_state_t;

    localparam logic [7:0] CMD_UNLOCK1   = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK2   = 8'h55;
    localparam logic [7:0] CMD_PROGRAM   = 8'hA0;
    localparam logic [7:0] CMD_ERASE_SET = 8'h80;
    localparam logic [7:0] CMD_SECTOR    = 8'h30;
    localparam logic [7:0] CMD_RESET     = 8'hF0;

endpackage

// File: rtl/flpoll_cmd_rom.sv
// Command sequence generator: maps a step index to the address/data of
// each write cycle for program (4 steps) or sector erase (6 steps).
// Assumes step never exceeds the last step of the selected operation.
module flpoll_cmd_rom
    import flpoll_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16,
    parameter logic [AW-1:0] UNLOCK_A = 'h555,
    parameter logic [AW-1:0] UNLOCK_B = 'h2AA
) (
    input  logic          is_erase,
    input  logic [2:0]    step,
    input  logic [AW-1:0] tgt_addr,
    input  logic [DW-1:0] pgm_data,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          last_step
);
    localparam int PAD = DW - 8;

    // Select the address/data pair for the current step.
    always_comb begin
        wr_addr   = UNLOCK_A;
        wr_data   = {{PAD{1'b0}}, CMD_UNLOCK1};
        last_step = 1'b0;
        if (!is_erase) begin
            case (step)
                3'd0: ;
                3'd1: begin wr_addr = UNLOCK_B; wr_data = {{PAD{1'b0}}, CMD_UNLOCK2}; end
                3'd2: wr_data = {{PAD{1'b0}}, CMD_PROGRAM};
                default: begin wr_addr = tgt_addr; wr_data = pgm_data; last_step = 1'b1; end
            endcase
        end else begin
            case (step)
                3'd0, 3'd3: ;
                3'd1, 3'd4: begin wr_addr = UNLOCK_B; wr_data = {{PAD{1'b0}}, CMD_UNLOCK2}; end
                3'd2: wr_data = {{PAD{1'b0}}, CMD_ERASE_SET};
                default: begin wr_addr = tgt_addr; wr_data = {{PAD{1'b0}}, CMD_SECTOR}; last_step = 1'b1; end
            endcase
        end
    end
endmodule

// File: rtl/flpoll_status_eval.sv
// Status word evaluation: compares the toggle bit of the newest read with
// the previously stored toggle bit and extracts the timeout flag.
// Assumes both bit positions lie inside the data word.
module flpoll_status_eval #(
    parameter int DW          = 16,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5
) (
    input  logic          prev_tog,
    input  logic [DW-1:0] cur,
    output logic          cur_tog,
    output logic          running,
    output logic          timed_out
);
    logic unused_other_bits;

    // Toggle comparison and timeout flag extraction.
    always_comb begin
        cur_tog           = cur[TOGGLE_BIT];
        running           = cur[TOGGLE_BIT] ^ prev_tog;
        timed_out         = cur[TIMEOUT_BIT];
        unused_other_bits = ^cur;
    end
endmodule

// File: rtl/flash_op_poller.sv
// Program / sector-erase controller with toggle-bit status polling.
// Issues the command writes, polls the status word at the target address,
// rechecks twice after a timeout flag, writes the reset command on failure,
// and steps through multi-word program requests.
// Assumes a single-outstanding bus: request held until a one-cycle ack.
module flash_op_poller
    import flpoll_pkg::*;
#(
    parameter int AW = 23,
    parameter int DW = 16,
    parameter int CW = 8,
    parameter int TOGGLE_BIT  = 6,
    parameter int TIMEOUT_BIT = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_erase,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] word_cnt,
    input  logic [DW-1:0] pgm_data,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic          word_taken,
    output logic          fl_req,
    output logic          fl_we,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_wdata,
    input  logic [DW-1:0] fl_rdata,
    input  logic          fl_ack
);
    localparam logic [CW-1:0] ONE = CW'(1);

    poll_state_t   state_q;
    logic [2:0]    step_q;
    logic [AW-1:0] addr_q;
    logic          erase_q;
    logic [CW-1:0] rem_q;
    logic          prev_tog_q;
    logic          done_q, err_q, taken_q;

    logic [AW-1:0] seq_addr;
    logic [DW-1:0] seq_data;
    logic          seq_last;
    logic          cur_tog, running, timed_out;
    logic          xfer, word_ok;

    flpoll_cmd_rom #(.AW(AW), .DW(DW)) i_cmd_rom (
        .is_erase (erase_q),
        .step     (step_q),
        .tgt_addr (addr_q),
        .pgm_data (pgm_data),
        .wr_addr  (seq_addr),
        .wr_data  (seq_data),
        .last_step(seq_last)
    );

    flpoll_status_eval #(.DW(DW), .TOGGLE_BIT(TOGGLE_BIT), .TIMEOUT_BIT(TIMEOUT_BIT)) i_eval (
        .prev_tog (prev_tog_q),
        .cur      (fl_rdata),
        .cur_tog  (cur_tog),
        .running  (running),
        .timed_out(timed_out)
    );

    // Bus request decode from the current state.
    always_comb begin
        fl_req   = (state_q != ST_IDLE);
        fl_we    = (state_q == ST_CMD) || (state_q == ST_RST_WR);
        fl_addr  = (state_q == ST_CMD) ? seq_addr : addr_q;
        fl_wdata = '0;
        if (state_q == ST_CMD)         fl_wdata = seq_data;
        else if (state_q == ST_RST_WR) fl_wdata = {{(DW-8){1'b0}}, CMD_RESET};
        xfer     = fl_req && fl_ack;
        word_ok  = xfer && !running &&
                   ((state_q == ST_RD_NEXT) || (state_q == ST_RCK_B));
    end

    assign busy       = fl_req;
    assign done       = done_q;
    assign error      = err_q;
    assign word_taken = taken_q;

    // Sequencer: commands, polling, recheck, reset write, word stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_q     <= '0;
            addr_q     <= '0;
            erase_q    <= 1'b0;
            rem_q      <= '0;
            prev_tog_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
            taken_q    <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            taken_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    addr_q  <= base_addr;
                    erase_q <= op_erase;
                    rem_q   <= (word_cnt == '0) ? ONE : word_cnt;
                    step_q  <= '0;
                    state_q <= ST_CMD;
                end
                ST_CMD: if (xfer) begin
                    if (seq_last) state_q <= ST_RD_FIRST;
                    else          step_q  <= step_q + 3'd1;
                end
                ST_RD_FIRST: if (xfer) begin
                    prev_tog_q <= cur_tog;
                    state_q    <= ST_RD_NEXT;
                end
                ST_RD_NEXT: if (xfer && running) begin
                    prev_tog_q <= cur_tog;
                    if (timed_out) state_q <= ST_RCK_A;
                end
                ST_RCK_A: if (xfer) begin
                    prev_tog_q <= cur_tog;
                    state_q    <= ST_RCK_B;
                end
                ST_RCK_B: if (xfer && running) state_q <= ST_RST_WR;
                ST_RST_WR: if (xfer) begin
                    err_q   <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
            if (word_ok) begin
                if (!erase_q && rem_q != ONE) begin
                    rem_q   <= rem_q - ONE;
                    addr_q  <= addr_q + AW'(1);
                    step_q  <= '0;
                    taken_q <= 1'b1;
                    state_q <= ST_CMD;
                end else begin
                    done_q  <= 1'b1;
                    taken_q <= !erase_q;
                    state_q <= ST_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/flash_op_poller_chk.sv
// Property checker for flash_op_poller, attached by bind.
// Assumes the synchronous active-low reset of the checked block.
module flash_op_poller_chk #(
    parameter int AW = 23,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic          fl_req,
    input logic          fl_we,
    input logic [AW-1:0] fl_addr,
    input logic [DW-1:0] fl_wdata,
    input logic          fl_ack
);
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && !fl_ack |=> fl_req && $stable(fl_we) && $stable(fl_addr) && $stable(fl_wdata));

    assert_no_done_and_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !busy);

    assert_busy_from_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_error_after_reset_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> $past(fl_req && fl_ack && fl_we && fl_wdata[7:0] == 8'hF0));

    assert_done_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(fl_req && fl_ack && !fl_we));
endmodule

bind flash_op_poller flash_op_poller_chk #(.AW(AW), .DW(DW)) i_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .error(error), .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_ack(fl_ack)
);

// File: tb/test_flash_op_poller.sv
`timescale 1ns/1ps
module test_flash_op_poller;
    localparam int AW = 23, DW = 16, CW = 8;
    localparam logic [AW-1:0] PA = 23'h012340, SA = 23'h400000;
    localparam logic [DW-1:0] DBASE = 16'h5A00;

    typedef struct packed {
        logic       erase;
        logic [7:0] cnt;
        logic [7:0] n;      // busy reads; 255 = never finishes
        logic [7:0] t;      // read index from which bit 5 is set; 0 = never
        logic       b2;     // bit 2 keeps toggling after completion
        logic       exp_err;
        logic [7:0] exp_rd;
        logic [7:0] exp_wr;
        logic [7:0] exp_wt;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd1, 8'd0,   8'd0, 1'b0, 1'b0, 8'd2, 8'd4,  8'd1}, // R2 R4 immediate
        '{1'b0, 8'd1, 8'd4,   8'd0, 1'b0, 1'b0, 8'd5, 8'd4,  8'd1}, // R4 long poll
        '{1'b1, 8'd1, 8'd3,   8'd0, 1'b0, 1'b0, 8'd4, 8'd6,  8'd0}, // R3 erase
        '{1'b1, 8'd1, 8'd2,   8'd3, 1'b0, 1'b0, 8'd3, 8'd6,  8'd0}, // R6 flag on stop read
        '{1'b0, 8'd1, 8'd3,   8'd3, 1'b0, 1'b0, 8'd5, 8'd4,  8'd1}, // R6 recheck passes
        '{1'b1, 8'd1, 8'd255, 8'd3, 1'b0, 1'b1, 8'd5, 8'd7,  8'd0}, // R7 erase fails
        '{1'b1, 8'd1, 8'd1,   8'd0, 1'b1, 1'b0, 8'd2, 8'd6,  8'd0}, // R5 bit 2 ignored
        '{1'b0, 8'd3, 8'd2,   8'd0, 1'b0, 1'b0, 8'd9, 8'd12, 8'd3}, // R8 three words
        '{1'b0, 8'd0, 8'd1,   8'd0, 1'b0, 1'b0, 8'd2, 8'd4,  8'd1}, // R8 zero count
        '{1'b0, 8'd2, 8'd255, 8'd2, 1'b0, 1'b1, 8'd4, 8'd5,  8'd0}  // R7 program fails
    };

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_erase = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] word_cnt = '0;
    logic [DW-1:0] pgm_data;
    logic          busy, done, error, word_taken, fl_req, fl_we;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_wdata;
    logic [DW-1:0] fl_rdata = '0;
    logic          fl_ack = 1'b0;

    int n_chk = 0, n_fail = 0;
    int wt_tot = 0, wt_base = 0;
    int rd_tot = 0, wr_tot = 0, bad_tot = 0;
    logic [7:0] m_n = 0, m_t = 0;
    logic       m_b2 = 0;
    logic [AW+DW-1:0] wlog [256];

    always #2 clk = ~clk;

    assign pgm_data = DBASE + DW'(wt_tot - wt_base);

    flash_op_poller #(.AW(AW), .DW(DW), .CW(CW)) i_flash_op_poller (
        .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
        .base_addr(base_addr), .word_cnt(word_cnt), .pgm_data(pgm_data),
        .busy(busy), .done(done), .error(error), .word_taken(word_taken),
        .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_ack(fl_ack)
    );

    // Count accepted words.
    always @(negedge clk) if (word_taken) wt_tot = wt_tot + 1;

    // Flash model: acks every other cycle, logs writes, produces status words.
    logic [DW-1:0] last_wd = '0;
    logic [AW-1:0] m_tgt = '0;
    int   busy_left = 0, rd_idx = 0;
    logic tog = 0, b2 = 0, m_erase = 0;
    always @(negedge clk) begin
        if (fl_ack) fl_ack = 1'b0;
        else if (fl_req) begin
            fl_ack = 1'b1;
            if (fl_we) begin
                wlog[wr_tot % 256] = {fl_addr, fl_wdata};
                wr_tot = wr_tot + 1;
                if (last_wd == 16'h00A0 || (fl_wdata == 16'h0030 && last_wd == 16'h0055)) begin
                    busy_left = m_n; rd_idx = 0; m_tgt = fl_addr;
                    m_erase = (last_wd != 16'h00A0);
                end
                if (fl_wdata == 16'h00F0) busy_left = 0;
                last_wd = fl_wdata;
            end else begin
                rd_tot = rd_tot + 1;
                rd_idx = rd_idx + 1;
                if (fl_addr != m_tgt) bad_tot = bad_tot + 1;
                if (busy_left > 0) begin
                    tog = ~tog;
                    if (m_erase) b2 = ~b2;
                    if (m_n != 8'd255) busy_left = busy_left - 1;
                end else if (m_b2) b2 = ~b2;
                fl_rdata = '0;
                fl_rdata[6] = tog;
                fl_rdata[5] = (m_t != 0) && (rd_idx >= m_t);
                fl_rdata[2] = b2;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [AW+DW-1:0] exp_write(input logic er, input int w, input logic [AW-1:0] base);
        int j = er ? w : w % 4;
        int k = er ? 0 : w / 4;
        if (!er) begin
            case (j)
                0: return {23'h555, 16'h00AA};
                1: return {23'h2AA, 16'h0055};
                2: return {23'h555, 16'h00A0};
                default: return {base + AW'(k), DBASE + DW'(k)};
            endcase
        end
        case (j)
            0, 3: return {23'h555, 16'h00AA};
            1, 4: return {23'h2AA, 16'h0055};
            2: return {23'h555, 16'h0080};
            default: return {base, 16'h0030};
        endcase
    endfunction

    // Compare logged writes against the expected sequence (R2, R3, R7, R8).
    task automatic check_seq(input logic er, input int snap, input int nwr,
                             input logic exp_err, input logic [AW-1:0] base, input string req);
        int bad = 0;
        for (int w = 0; w < nwr; w++) begin
            logic [AW+DW-1:0] got = wlog[(snap + w) % 256];
            if (exp_err && w == nwr - 1) begin
                if (got[DW-1:0] != 16'h00F0) bad++;
            end else if (got != exp_write(er, w, base)) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic run_op(input logic er, input logic [7:0] cnt, input logic poke,
                          output int nd, output int ne);
        int cyc = 0;
        base_addr = er ? SA : PA; op_erase = er; word_cnt = cnt; start = 1'b1;
        wt_base = wt_tot;
        @(negedge clk); start = 1'b0;
        nd = 0; ne = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            chk(busy == 1'b1, "R9 busy mid-op", busy, 1);
            base_addr = SA; op_erase = 1'b1; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (nd + ne == 0 && cyc < 4000) begin
            @(negedge clk); cyc++;
            if (done) nd++;
            if (error) ne++;
        end
        if (cyc >= 4000) chk(1'b0, "watchdog", cyc, 0);
        repeat (4) begin
            @(negedge clk);
            if (done) nd++;
            if (error) ne++;
        end
    endtask

    initial begin
        int nd, ne, s_rd, s_wr, s_bad;
        repeat (3) @(negedge clk);
        chk({busy, done, error, word_taken, fl_req} == 5'b0, "R1 in reset", busy, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy, done, error, word_taken, fl_req} == 5'b0, "R1 after reset", fl_req, 0);

        for (int v = 0; v < NV; v++) begin
            m_n = VECS[v].n; m_t = VECS[v].t; m_b2 = VECS[v].b2;
            s_rd = rd_tot; s_wr = wr_tot; s_bad = bad_tot;
            run_op(VECS[v].erase, VECS[v].cnt, 1'b0, nd, ne);
            chk(nd == (VECS[v].exp_err ? 0 : 1) && ne == (VECS[v].exp_err ? 1 : 0),
                VECS[v].exp_err ? "R7 error pulse" : "R9 done pulse", nd * 10 + ne,
                VECS[v].exp_err ? 1 : 10);
            chk(rd_tot - s_rd == int'(VECS[v].exp_rd), "R4 R5 R6 read count",
                rd_tot - s_rd, VECS[v].exp_rd);
            chk(wr_tot - s_wr == int'(VECS[v].exp_wr), "R2 R3 R7 write count",
                wr_tot - s_wr, VECS[v].exp_wr);
            chk(wt_tot - wt_base == int'(VECS[v].exp_wt), "R8 word_taken count",
                wt_tot - wt_base, VECS[v].exp_wt);
            chk(bad_tot == s_bad, "R4 read address", bad_tot - s_bad, 0);
            check_seq(VECS[v].erase, s_wr, wr_tot - s_wr, VECS[v].exp_err,
                      VECS[v].erase ? SA : PA, "R2 R3 R8 write sequence");
            chk(!busy, "R9 idle after end", busy, 0);
        end

        // Directed: start while busy is ignored (R9).
        m_n = 8'd4; m_t = 8'd0; m_b2 = 1'b0;
        s_rd = rd_tot; s_wr = wr_tot;
        run_op(1'b0, 8'd1, 1'b1, nd, ne);
        chk(nd == 1 && ne == 0, "R9 start ignored outcome", nd, 1);
        chk(wr_tot - s_wr == 4 && rd_tot - s_rd == 5, "R9 start ignored traffic",
            wr_tot - s_wr, 4);
        check_seq(1'b0, s_wr, wr_tot - s_wr, 1'b0, PA, "R9 start ignored sequence");

        // Directed: reset in mid-operation returns to the idle outputs (R1).
        base_addr = PA; op_erase = 1'b0; word_cnt = 8'd1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk({busy, done, error, word_taken, fl_req} == 5'b0, "R1 reset mid-op", busy, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule